// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer/Counter

This block is one 16-bit up/down counter whose source of count steps is chosen by a two-bit mode field. It can step from the system clock through a power-of-two prescaler, step from the same prescaler only while an external gate pin is high, step on rising edges of an external pin, or decode a pair of quadrature sensor signals so that the count follows the position of a rotary or linear encoder. The prescaler select picks a divider from 8 up to 1024.

Both external pins are brought into the clock domain through two-flop synchronizers before any edge or level is used. A run bit enables stepping in every mode. Outside quadrature mode, the count direction comes from a direction bit combined with the second pin, so software or hardware can reverse the count. A write port loads the count at any time. Every wrap past the top or bottom of the range raises a one-cycle pulse. A direction output shows which way the counter is currently stepping.

Top module: `tmr_multimode`

## Requirements
- R1: After a synchronous reset, `count` is 0x0000, `wrapPulse` is 0 and, with `dirDown` and `pinAux` low, `countDown` is 0.
- R2: In prescaled timer mode (`mode`=00) with `run` high, the counter steps once every 2^(3+`preSel`) clock cycles, so code 0 divides by 8 and code 7 by 1024. The prescaler phase restarts from zero whenever `run` is low. While `run` stays high for K cycles, the counter therefore steps floor(K/divider) times.
- R3: In gated mode (`mode`=01), the prescaler advances only while the synchronized `pinIn` is high. While the gate is low, the prescaler keeps its phase, so gate-high intervals add up.
- R4: In event mode (`mode`=10), each rising edge of `pinIn` steps the counter once, whatever `preSel` is.
- R5: In quadrature mode (`mode`=11), `pinIn` is A and `pinAux` is B. Each change of exactly one of them steps the count once. The step is up for the sequence AB = 00,10,11,01,00 (A leading) and down for the reverse order (B leading).
- R6: In quadrature mode, a change of A and B in the same sample leaves the count and `countDown` unchanged.
- R7: Outside quadrature mode, the counter counts down when `dirDown` XOR the synchronized `pinAux` is 1, and up otherwise.
- R8: Counting up from 0xFFFF gives 0x0000, and counting down from 0x0000 gives 0xFFFF. Each wrap raises `wrapPulse` for exactly one cycle, in the cycle after the wrapping step.
- R9: When `wrEn` is high, the next count is `wrData`. This holds even if a step falls in the same cycle, and a load never raises `wrapPulse`.
- R10: With `run` low, no mode changes the count. Pin edges seen while `run` is low are not stored.
- R11: In quadrature mode, `countDown` shows the direction of the last valid quadrature step (1 = down, 0 after reset). In the other modes it shows the direction set by R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 00 timer, 01 gated, 10 event, 11 quadrature |
| preSel | input | 3 | Prescaler code, divider 2^(3+code) |
| run | input | 1 | Enables stepping in all modes |
| dirDown | input | 1 | Direction bit for the non-quadrature modes |
| pinIn | input | 1 | Gate, event input or quadrature A |
| pinAux | input | 1 | Direction control or quadrature B |
| wrEn | input | 1 | Load strobe for the count |
| wrData | input | 16 | Value loaded into the count |
| count | output | 16 | Current count |
| wrapPulse | output | 1 | One-cycle overflow/underflow pulse |
| countDown | output | 1 | Current direction, 1 = down |

## Verification
A register load and a count step can fall in the same clock edge. That edge is also the one most likely to wrap, when the count sits at 0xFFFF. The bench preloads 0xFFFF, starts the divide-by-8 timer and raises the write strobe so that it is active exactly on the eighth enabled edge, where the prescaler terminal step lands. It judges the result by requiring the written value, not 0x0000 or 0x0000 plus a step, and by requiring that no wrap pulse is seen in that cycle or afterwards.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_TIMER = 2'b00,
    MODE_GATED = 2'b01,
    MODE_EVENT = 2'b10,
    MODE_QUAD  = 2'b11
  } tmr_mode_e;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic load;  // write port wins
    logic step;  // advance by one
    logic down;  // direction of the step
  } tmr_strobe_t;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= asyncIn;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[g] <= '0;
      else     stage[g] <= stage[g-1];
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int PRE_SEL_W     = 3,
  parameter int PRE_BASE_LOG2 = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  tmr_mode_e            mode,
  input  logic [PRE_SEL_W-1:0] preSel,
  input  logic                 run,
  input  logic                 dirDown,
  input  logic                 wrEn,
  input  logic [1:0]           inSync,   // bit0 pin/A, bit1 aux/B
  output tmr_strobe_t          strobe,
  output logic                 dirInd
);

  localparam int PRE_W = PRE_BASE_LOG2 + (1 << PRE_SEL_W) - 1;

  logic [1:0]       prevIn;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W:0]   divFull;
  logic [PRE_W-1:0] divMax;
  logic             quadDir;

  logic pinS, auxS, cfgDown, pinRise, aChg, bChg, quadValid, quadUp;
  logic preEn, preTick;

  assign pinS    = inSync[0];
  assign auxS    = inSync[1];
  assign cfgDown = dirDown ^ auxS;
  assign pinRise = pinS & ~prevIn[0];
  assign aChg    = pinS ^ prevIn[0];
  assign bChg    = auxS ^ prevIn[1];

  // exactly one of A/B moved; sense from which one and the other's level
  assign quadValid = aChg ^ bChg;
  assign quadUp    = aChg ? (pinS != auxS) : (auxS == pinS);

  assign divFull = (PRE_W+1)'(1) << (PRE_BASE_LOG2 + int'(preSel));
  assign divMax  = PRE_W'(divFull - 1'b1);

  assign preEn   = run && ((mode == MODE_TIMER) || ((mode == MODE_GATED) && pinS));
  assign preTick = preEn && (preCnt == divMax);

  always_comb begin
    strobe.load = wrEn;
    strobe.step = 1'b0;
    strobe.down = cfgDown;
    unique case (mode)
      MODE_TIMER, MODE_GATED: strobe.step = preTick;
      MODE_EVENT:             strobe.step = run && pinRise;
      MODE_QUAD: begin
        strobe.step = run && quadValid;
        strobe.down = ~quadUp;
      end
      default: strobe.step = 1'b0;
    endcase
  end

  assign dirInd = (mode == MODE_QUAD) ? quadDir : cfgDown;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevIn  <= '0;
      preCnt  <= '0;
      quadDir <= 1'b0;
    end else begin
      prevIn <= inSync;
      if (!run || mode == MODE_EVENT || mode == MODE_QUAD) preCnt <= '0;
      else if (preTick)                                    preCnt <= '0;
      else if (preEn)                                      preCnt <= PRE_W'(preCnt + 1'b1);
      if (mode == MODE_QUAD && run && quadValid) quadDir <= ~quadUp;
    end
  end

  // R10: nothing steps while stopped
  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    !run |-> !strobe.step);

  // R6: simultaneous A/B change is rejected
  a_r6_double_edge: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_QUAD && (inSync ^ prevIn) == 2'b11) |-> !strobe.step);

  // R3: closed gate blocks stepping
  a_r3_gate_closed: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_GATED && !inSync[0]) |-> !strobe.step);

  // R2: prescaled steps are never back to back
  a_r2_spacing: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_TIMER && strobe.step) |=> (mode != MODE_TIMER || !strobe.step));

  // R11: quadrature direction indicator follows the last valid step
  a_r11_quad_dir: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_QUAD && strobe.step) |=> (mode != MODE_QUAD || dirInd == $past(strobe.down)));

endmodule

// File: rtl/tmr_dpath.sv
module tmr_dpath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  tmr_strobe_t      strobe,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic             wrapPulse
);

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '0;
      wrapPulse <= 1'b0;
    end else begin
      wrapPulse <= 1'b0;
      if (strobe.load) begin
        count <= wrData;
      end else if (strobe.step) begin
        if (strobe.down) begin
          count     <= count - 1'b1;
          wrapPulse <= (count == '0);
        end else begin
          count     <= count + 1'b1;
          wrapPulse <= (count == '1);
        end
      end
    end
  end

  // R9: load wins and never reports a wrap
  a_r9_load_wins: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> (count == $past(wrData) && !wrapPulse));

  // R8: upward wrap
  a_r8_up_wrap: assert property (@(posedge clk) disable iff (rst)
    (strobe.step && !strobe.load && !strobe.down && count == '1) |=> (count == '0 && wrapPulse));

  // R8: downward wrap
  a_r8_down_wrap: assert property (@(posedge clk) disable iff (rst)
    (strobe.step && !strobe.load && strobe.down && count == '0) |=> (count == '1 && wrapPulse));

  // R8: pulse lasts one cycle
  a_r8_pulse_single: assert property (@(posedge clk) disable iff (rst)
    wrapPulse |=> !wrapPulse);

  // R10: no strobe, no change
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!strobe.step && !strobe.load) |=> ($stable(count) && !wrapPulse));

endmodule

// File: rtl/tmr_multimode.sv
module tmr_multimode
  import tmr_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int PRE_SEL_W     = 3,
  parameter int PRE_BASE_LOG2 = 3,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           mode,
  input  logic [PRE_SEL_W-1:0] preSel,
  input  logic                 run,
  input  logic                 dirDown,
  input  logic                 pinIn,
  input  logic                 pinAux,
  input  logic                 wrEn,
  input  logic [CNT_W-1:0]     wrData,
  output logic [CNT_W-1:0]     count,
  output logic                 wrapPulse,
  output logic                 countDown
);

  logic [1:0]  inSync;
  tmr_strobe_t strobe;

  tmr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst     (rst),
    .asyncIn ({pinAux, pinIn}),
    .syncOut (inSync)
  );

  tmr_ctrl #(.PRE_SEL_W(PRE_SEL_W), .PRE_BASE_LOG2(PRE_BASE_LOG2)) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .mode    (tmr_mode_e'(mode)),
    .preSel  (preSel),
    .run     (run),
    .dirDown (dirDown),
    .wrEn    (wrEn),
    .inSync  (inSync),
    .strobe  (strobe),
    .dirInd  (countDown)
  );

  tmr_dpath #(.CNT_W(CNT_W)) i_dpath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .wrData    (wrData),
    .count     (count),
    .wrapPulse (wrapPulse)
  );

endmodule

// File: tb/test_tmr_multimode.sv
module test_tmr_multimode;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'b00;
  logic [2:0]  preSel = 3'd0;
  logic        run = 1'b0, dirDown = 1'b0, pinIn = 1'b0, pinAux = 1'b0, wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] count;
  logic        wrapPulse, countDown;

  int nChecks = 0, nErrors = 0, wrapSeen = 0;
  bit finished = 1'b0;
  logic [15:0] exp;

  always #2 clk = ~clk;

  tmr_multimode i_tmr_multimode (
    .clk(clk), .rst(rst), .mode(mode), .preSel(preSel), .run(run), .dirDown(dirDown),
    .pinIn(pinIn), .pinAux(pinAux), .wrEn(wrEn), .wrData(wrData),
    .count(count), .wrapPulse(wrapPulse), .countDown(countDown)
  );

  always @(negedge clk) if (!rst && wrapPulse) wrapSeen++;

  task automatic chk(string req, int act, int expv);
    nChecks++;
    if (act != expv) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadCount(logic [15:0] v);
    wrEn = 1'b1; wrData = v;
    waitN(1);
    wrEn = 1'b0;
  endtask

  function automatic logic [15:0] timerExp(logic [15:0] v, int k, int sel, bit down);
    int steps = k >> (3 + sel);
    return down ? 16'(v - steps) : 16'(v + steps);
  endfunction

  task automatic runFor(int k);
    run = 1'b1;
    waitN(k);
    run = 1'b0;
  endtask

  task automatic gatePulse(int k);
    pinIn = 1'b1; waitN(k);
    pinIn = 1'b0; waitN(5);
  endtask

  task automatic evPulse();
    pinIn = 1'b1; waitN(3);
    pinIn = 1'b0; waitN(3);
  endtask

  task automatic qset(logic a, logic b);
    pinIn = a; pinAux = b;
    waitN(4);
  endtask

  initial begin
    #(4 * 150000);
    nChecks++; nErrors++;
    $display("FAIL watchdog actual=hung expected=done");
    if (!finished) $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c));
    waitN(3);
    rst = 1'b0;
    waitN(1);
    // R1 reset state
    chk("R1 count", count, 16'h0);
    chk("R1 wrap", wrapPulse, 0);
    chk("R1 dir", countDown, 0);

    // R2 directed: largest divider
    mode = 2'b00; preSel = 3'd7;
    loadCount(16'h0100);
    runFor(2048 + 5);
    chk("R2 div1024", count, 16'h0102);

    // R2/R7 random timer runs
    for (int i = 0; i < 20; i++) begin
      int s = $urandom % 4;
      int k = $urandom % 300;
      bit d = 1'($urandom);
      logic [15:0] v = 16'($urandom);
      preSel = 3'(s); dirDown = d;
      loadCount(v);
      runFor(k);
      chk("R2 timer", count, timerExp(v, k, s, d));
    end
    dirDown = 1'b0;

    // R7 aux pin reverses direction
    pinAux = 1'b1; preSel = 3'd0;
    waitN(4);
    chk("R7 dirInd", countDown, 1);
    loadCount(16'h0050);
    runFor(16);
    chk("R7 aux down", count, 16'h004E);
    pinAux = 1'b0; waitN(4);
    chk("R11 cfg dir", countDown, 0);

    // R8 wraps
    wrapSeen = 0;
    loadCount(16'hFFFF);
    runFor(8);
    chk("R8 up value", count, 16'h0000);
    chk("R8 pulse on", wrapPulse, 1);
    waitN(1);
    chk("R8 pulse off", wrapPulse, 0);
    dirDown = 1'b1;
    loadCount(16'h0000);
    runFor(8);
    chk("R8 down value", count, 16'hFFFF);
    waitN(2);
    chk("R8 wrap count", wrapSeen, 2);
    dirDown = 1'b0;

    // R9 load collides with a wrapping step
    wrapSeen = 0;
    loadCount(16'hFFFF);
    run = 1'b1;
    waitN(7);
    wrEn = 1'b1; wrData = 16'h1234;
    waitN(1);
    wrEn = 1'b0; run = 1'b0;
    chk("R9 load wins", count, 16'h1234);
    chk("R9 no pulse", wrapPulse, 0);
    waitN(3);
    chk("R9 no wrap seen", wrapSeen, 0);

    // R3 gated accumulation
    mode = 2'b01; preSel = 3'd0;
    loadCount(16'h0000);
    run = 1'b1; waitN(4);
    gatePulse(13);
    chk("R3 first gate", count, 16'h0001);
    waitN(20);
    chk("R3 gate closed", count, 16'h0001);
    gatePulse(5);
    chk("R3 phase kept", count, 16'h0002);
    run = 1'b0;

    // R4 event counting, random pulse counts
    mode = 2'b10; preSel = 3'd5;
    loadCount(16'h0010);
    exp = 16'h0010;
    run = 1'b1;
    for (int i = 0; i < 6; i++) begin
      int n = 1 + $urandom % 5;
      for (int j = 0; j < n; j++) evPulse();
      exp = 16'(exp + n);
      chk("R4 events", count, exp);
    end
    // R10 run low ignores events
    run = 1'b0;
    evPulse(); evPulse();
    run = 1'b1; waitN(4);
    chk("R10 events ignored", count, exp);
    run = 1'b0;

    // R5/R6/R11 quadrature random walk
    mode = 2'b11;
    qset(1'b0, 1'b0);
    loadCount(16'h8000);
    exp = 16'h8000;
    begin
      int idx = 0;
      bit lastDown = 1'b0;
      logic [1:0] seqAB [4] = '{2'b00, 2'b10, 2'b11, 2'b01};
      run = 1'b1;
      // R10 quad with run low first: one step ignored
      run = 1'b0;
      qset(seqAB[1][1], seqAB[1][0]);
      chk("R10 quad idle", count, exp);
      idx = 1;
      run = 1'b1;
      for (int i = 0; i < 150; i++) begin
        int r = $urandom % 8;
        if (r == 0) begin
          idx = (idx + 2) % 4;
          qset(seqAB[idx][1], seqAB[idx][0]);
          chk("R6 double edge", count, exp);
          chk("R6 dir kept", countDown, lastDown);
        end else if (r < 5) begin
          idx = (idx + 1) % 4;
          qset(seqAB[idx][1], seqAB[idx][0]);
          exp = 16'(exp + 1); lastDown = 1'b0;
          chk("R5 A leads", count, exp);
          chk("R11 quad up", countDown, 0);
        end else begin
          idx = (idx + 3) % 4;
          qset(seqAB[idx][1], seqAB[idx][0]);
          exp = 16'(exp - 1); lastDown = 1'b1;
          chk("R5 B leads", count, exp);
          chk("R11 quad down", countDown, 1);
        end
      end
      run = 1'b0;
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule